// File: doc/BRIEF.md
# Three-Wire Half-Duplex Serial Master

This block runs transactions with a serial peripheral over three wires: an active-high enable, a serial clock that idles low, and one data line that carries traffic in both directions. The host places a request with a 6-bit register address, a direction flag, a byte count and up to `MAX_BYTES` bytes of write data. The engine raises the enable and sends a command byte. It then either sends the data bytes or releases the data line and receives the same number of bytes. Every byte moves least significant bit first.

Received bytes return to the host one at a time over a valid/ready pair. When a received byte has not been taken, the engine holds the serial clock high and waits. A runtime half-period setting divides the system clock down to the serial clock rate. The host sets it so the serial clock stays under the peripheral's limit: 2 MHz at the higher supply voltage and 500 kHz at the lowest. The pad tristate is controlled by the `sdaOe` output.

Top module: `tw_serial_master`

## Requirements
- R1: While reset is asserted and after it is released, `ce`, `sclk`, `sdaOe`, `busy` and `rdValid` are all low.
- R2: The first byte of each transaction has bit 7 set, the address in bits 6..1, and bit 0 equal to 1 for a read and 0 for a write. It is sent bit 0 first.
- R3: On a write, byte i is `reqWdata[8*i+7:8*i]`, with byte 0 sent first and each byte sent bit 0 first. The peripheral takes the bytes as consecutive addresses starting at the command address and wrapping modulo 64.
- R4: `sclk` is low whenever `ce` is low. `sdaOut` changes only while `sclk` is low, so it is stable during each high phase.
- R5: Every serial clock half-period lasts `divHalf`+1 system cycles, using the value captured at acceptance. `ce` rises two half-periods before the first rising edge of `sclk`. It falls two half-periods after the last falling edge.
- R6: On a read, `sdaOe` drops on the falling `sclk` edge that ends the eighth command bit. It stays low until the transaction ends.
- R7: On a read, the data line is sampled in the last system cycle of each low half-period, bit 0 first. Each byte is presented on `rdData` with `rdValid`, in address order, and holds until `rdReady` is seen high.
- R8: A request with count N, where 1 ≤ N ≤ `MAX_BYTES`, moves exactly N data bytes within a single `ce` window. That window lasts 16·(N+1)+3 half-periods.
- R9: `busy` rises on the cycle after a request is accepted and falls together with `ce`. A request presented while `busy` is high is ignored and does not change the transaction in progress.
- R10: A request with count 0 or greater than `MAX_BYTES` is refused: `busy` and `ce` stay low.
- R11: If a read byte has not been taken when the next byte completes, `sclk` stays high and `busy` stays high until the host accepts it. No byte is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| divHalf | input | DIV_W | Serial clock half-period minus one, in system cycles |
| reqValid | input | 1 | Request strobe, accepted when `busy` is low |
| reqRead | input | 1 | 1 = read, 0 = write |
| reqAddr | input | 6 | Start register address |
| reqLen | input | LEN_W | Number of data bytes |
| reqWdata | input | 8*MAX_BYTES | Write bytes, byte 0 in the low bits |
| busy | output | 1 | Transaction in progress |
| rdValid | output | 1 | Received byte available |
| rdData | output | 8 | Received byte |
| rdReady | input | 1 | Host takes the received byte |
| ce | output | 1 | Peripheral enable, active high |
| sclk | output | 1 | Serial clock |
| sdaOut | output | 1 | Data line value when driven |
| sdaOe | output | 1 | Data line output enable |
| sdaIn | input | 1 | Data line value from the pad |

## Verification
The bench builds the block with `MAX_BYTES` = 4 and `DIV_W` = 4. With these values a full-length burst is short enough to compare cycle by cycle. The 3-bit count field can also express lengths 5 to 7, which makes the refusal of oversized requests reachable. The half-period is changed at runtime between 0, 1, 2 and 3. This covers the one-cycle minimum, where a sample and a data change fall on adjacent cycles. The 4-byte bursts start at address 62, so the peripheral model wraps its address. A long host stall during a 3-byte read forces the clock hold.

// File: rtl/twsm_pkg.sv
package twsm_pkg;

  localparam int ADDR_W = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_TRAIL
  } twsmState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic run;       // divider counting
    logic accept;    // request taken this cycle
    logic shiftTx;   // next bit of the current byte
    logic loadNext;  // next write byte into the shifter
    logic sampleRx;  // capture data line
    logic pushRd;    // hand received byte to host
  } twsmStrobe_t;

  function automatic logic [7:0] cmdByte(input logic [ADDR_W-1:0] addr, input logic isRead);
    return {1'b1, addr, isRead};
  endfunction

endpackage

// File: rtl/twsm_ctrl.sv
module twsm_ctrl
  import twsm_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int LEN_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqRead,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             tick,
  input  logic             rdValid,
  output twsmStrobe_t      strb,
  output logic             busy,
  output logic             ce,
  output logic             sclk,
  output logic             sdaOe
);

  twsmState_t       state;
  logic             phase;
  logic [2:0]       bitIdx;
  logic [LEN_W-1:0] bytesLeft;
  logic             inCmd;
  logic             isRead;

  logic lenOk, acceptNow, readData, lastBit, stall;

  assign lenOk     = (reqLen != '0) && (reqLen <= LEN_W'(MAX_BYTES));
  assign acceptNow = (state == ST_IDLE) && reqValid && lenOk;
  assign readData  = isRead && !inCmd;
  assign lastBit   = (bitIdx == 3'd7);
  assign stall     = lastBit && readData && rdValid;
  assign busy      = (state != ST_IDLE);

  always_comb begin
    strb        = '0;
    strb.run    = (state != ST_IDLE);
    strb.accept = acceptNow;
    if (state == ST_LOW && tick)
      strb.sampleRx = readData;
    if (state == ST_HIGH && tick && !stall) begin
      if (!lastBit) begin
        strb.shiftTx = 1'b1;
      end else begin
        strb.pushRd   = readData;
        strb.loadNext = !isRead && (inCmd || bytesLeft != '0);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      phase     <= 1'b0;
      bitIdx    <= '0;
      bytesLeft <= '0;
      inCmd     <= 1'b0;
      isRead    <= 1'b0;
      ce        <= 1'b0;
      sclk      <= 1'b0;
      sdaOe     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (acceptNow) begin
          state     <= ST_LEAD;
          ce        <= 1'b1;
          sdaOe     <= 1'b1;
          phase     <= 1'b0;
          bitIdx    <= '0;
          inCmd     <= 1'b1;
          isRead    <= reqRead;
          bytesLeft <= reqLen;
        end
        ST_LEAD: if (tick) begin
          if (phase) begin
            state <= ST_HIGH;
            sclk  <= 1'b1;
          end else begin
            phase <= 1'b1;
          end
        end
        ST_LOW: if (tick) begin
          state <= ST_HIGH;
          sclk  <= 1'b1;
        end
        ST_HIGH: if (tick && !stall) begin
          sclk <= 1'b0;
          if (!lastBit) begin
            bitIdx <= bitIdx + 3'd1;
            state  <= ST_LOW;
          end else begin
            bitIdx <= '0;
            if (inCmd) begin
              inCmd     <= 1'b0;
              bytesLeft <= bytesLeft - 1'b1;
              if (isRead) sdaOe <= 1'b0;
              state <= ST_LOW;
            end else if (bytesLeft == '0) begin
              state <= ST_TRAIL;
              sdaOe <= 1'b0;
              phase <= 1'b0;
            end else begin
              bytesLeft <= bytesLeft - 1'b1;
              state     <= ST_LOW;
            end
          end
        end
        ST_TRAIL: if (tick) begin
          if (!phase) begin
            phase <= 1'b1;
          end else if (!rdValid) begin
            state <= ST_IDLE;
            ce    <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    !ce |-> !sclk) else $error("sclk high outside enable window");

  assert_busy_window_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy == ce) else $error("busy and enable disagree");

  assert_released_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && readData) |-> !sdaOe) else $error("line driven during read data");

  assert_no_overwrite_R11: assert property (@(posedge clk) disable iff (!rstN)
    strb.pushRd |-> !rdValid) else $error("read byte pushed over pending byte");

endmodule

// File: rtl/twsm_datapath.sv
module twsm_datapath
  import twsm_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int DIV_W     = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  twsmStrobe_t            strb,
  input  logic [DIV_W-1:0]       divHalf,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic                   reqRead,
  input  logic [8*MAX_BYTES-1:0] reqWdata,
  input  logic                   sdaIn,
  input  logic                   rdReady,
  output logic                   tick,
  output logic                   sdaOut,
  output logic                   rdValid,
  output logic [7:0]             rdData
);

  localparam int WBUF_W = 8 * MAX_BYTES;

  logic [DIV_W-1:0]  divCnt, divLat;
  logic [7:0]        txShift, rxShift;
  logic [WBUF_W-1:0] wBuf;

  assign tick   = strb.run && (divCnt == divLat);
  assign sdaOut = txShift[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt  <= '0;
      divLat  <= '0;
      txShift <= '0;
      rxShift <= '0;
      wBuf    <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      if (strb.accept) divLat <= divHalf;
      if (!strb.run || tick) divCnt <= '0;
      else                   divCnt <= divCnt + 1'b1;

      if (strb.accept) begin
        txShift <= cmdByte(reqAddr, reqRead);
        wBuf    <= reqWdata;
      end else if (strb.loadNext) begin
        txShift <= wBuf[7:0];
        wBuf    <= wBuf >> 8;
      end else if (strb.shiftTx) begin
        txShift <= {1'b0, txShift[7:1]};
      end

      if (strb.sampleRx) rxShift <= {sdaIn, rxShift[7:1]};

      if (strb.pushRd) begin
        rdData  <= rxShift;
        rdValid <= 1'b1;
      end else if (rdValid && rdReady) begin
        rdValid <= 1'b0;
      end
    end
  end

  assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdData)))
    else $error("read byte dropped before handshake");

endmodule

// File: rtl/tw_serial_master.sv
module tw_serial_master
  import twsm_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int DIV_W     = 8,
  parameter int LEN_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [DIV_W-1:0]       divHalf,
  input  logic                   reqValid,
  input  logic                   reqRead,
  input  logic [5:0]             reqAddr,
  input  logic [LEN_W-1:0]       reqLen,
  input  logic [8*MAX_BYTES-1:0] reqWdata,
  output logic                   busy,
  output logic                   rdValid,
  output logic [7:0]             rdData,
  input  logic                   rdReady,
  output logic                   ce,
  output logic                   sclk,
  output logic                   sdaOut,
  output logic                   sdaOe,
  input  logic                   sdaIn
);

  twsmStrobe_t strb;
  logic        tick;

  twsm_ctrl #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRead(reqRead),
    .reqLen(reqLen), .tick(tick), .rdValid(rdValid), .strb(strb),
    .busy(busy), .ce(ce), .sclk(sclk), .sdaOe(sdaOe)
  );

  twsm_datapath #(.MAX_BYTES(MAX_BYTES), .DIV_W(DIV_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .divHalf(divHalf),
    .reqAddr(reqAddr), .reqRead(reqRead), .reqWdata(reqWdata),
    .sdaIn(sdaIn), .rdReady(rdReady), .tick(tick), .sdaOut(sdaOut),
    .rdValid(rdValid), .rdData(rdData)
  );

  assert_dout_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ce && sclk) |-> $stable(sdaOut)) else $error("data changed while clock high");

  assert_accept_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ce) |-> $past(!busy && reqValid)) else $error("enable rose without idle request");

endmodule

// File: tb/tw_serial_master_tb.sv
module tw_serial_master_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TB_MAX     = 4;
  localparam int TB_DIV_W   = 4;
  localparam int TB_LEN_W   = $clog2(TB_MAX + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [TB_DIV_W-1:0] divHalf = '0;
  logic reqValid = 1'b0, reqRead = 1'b0;
  logic [5:0] reqAddr = '0;
  logic [TB_LEN_W-1:0] reqLen = '0;
  logic [8*TB_MAX-1:0] reqWdata = '0;
  logic busy, rdValid, ce, sclk, sdaOut, sdaOe;
  logic [7:0] rdData;
  logic rdReady = 1'b1;
  logic sdaIn = 1'b0;

  int nRun = 0, nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_serial_master #(.MAX_BYTES(TB_MAX), .DIV_W(TB_DIV_W)) dut_i (
    .clk(clk), .rstN(rstN), .divHalf(divHalf), .reqValid(reqValid),
    .reqRead(reqRead), .reqAddr(reqAddr), .reqLen(reqLen), .reqWdata(reqWdata),
    .busy(busy), .rdValid(rdValid), .rdData(rdData), .rdReady(rdReady),
    .ce(ce), .sclk(sclk), .sdaOut(sdaOut), .sdaOe(sdaOe), .sdaIn(sdaIn)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // behavioural peripheral on the three wires
  logic [7:0] devMem [64];
  logic [7:0] expMem [64];
  logic [7:0] pCmd = '0;
  logic [7:0] wTmp = '0;
  int rc = 0;
  logic prevSclk = 1'b0, prevCe = 1'b0;

  always @(negedge clk) begin
    if (ce && !prevCe) rc = 0;
    if (ce && sclk && !prevSclk) begin
      if (rc < 8) pCmd[rc] = sdaOut;
      else if (!pCmd[0]) begin
        wTmp[(rc-8)%8] = sdaOut;
        if ((rc-8)%8 == 7) devMem[(int'(pCmd[6:1]) + (rc-8)/8) % 64] = wTmp;
      end
      rc++;
    end
    if (ce && !sclk && prevSclk && pCmd[0] && rc >= 8)
      sdaIn = devMem[(int'(pCmd[6:1]) + (rc-8)/8) % 64][(rc-8)%8];
    prevSclk = sclk;
    prevCe   = ce;
  end

  logic [7:0] rxQ [$];
  always @(negedge clk) if (rdValid && rdReady) rxQ.push_back(rdData);

  // issue a request and compare pins against a half-period timeline every cycle
  task automatic runTxn(input bit rd, input logic [5:0] addr, input int len,
                        input logic [8*TB_MAX-1:0] wdata, input int div, input bit poke);
    logic [8*(TB_MAX+1)-1:0] stream;
    int p, nb, hTot;
    stream = {wdata, 1'b1, addr, rd};
    p = div + 1;
    nb = 8 * (len + 1);
    hTot = 2 * nb + 3;
    rxQ.delete();
    @(negedge clk);
    divHalf = TB_DIV_W'(div); reqValid = 1'b1; reqRead = rd; reqAddr = addr;
    reqLen = TB_LEN_W'(len); reqWdata = wdata;
    @(negedge clk);
    reqValid = 1'b0;
    for (int k = 0; k <= hTot * p; k++) begin
      int h, g;
      bit eCe, eSclk, eOe, eDout, bad;
      h = k / p;
      eCe = (h < hTot);
      eSclk = (h >= 2) && (h % 2 == 0) && (h <= 2 * nb);
      eOe = rd ? (h < 17) : (h < 2 * nb + 1);
      g = (h < 2) ? 0 : (h - 1) / 2;
      eDout = (g < nb) ? stream[g] : 1'b0;
      bad = (ce != eCe) || (busy != eCe) || (sclk != eSclk) || (sdaOe != eOe) ||
            (eOe && sdaOut != eDout);
      chk(!bad, "R4/R5/R6/R8/R9 pin timeline",
          int'({ce, busy, sclk, sdaOe, sdaOut}), int'({eCe, eCe, eSclk, eOe, eDout}));
      if (poke && k == 3) begin
        reqValid = 1'b1; reqAddr = ~addr; reqRead = ~rd; reqLen = 1;
      end
      if (poke && k == 4) reqValid = 1'b0;
      @(negedge clk);
    end
    chk(pCmd == {1'b1, addr, rd}, "R2 command byte", int'(pCmd), int'({1'b1, addr, rd}));
    if (rd) begin
      chk(rxQ.size() == len, "R8 read byte count", rxQ.size(), len);
      for (int i = 0; i < len && i < rxQ.size(); i++)
        chk(rxQ[i] == expMem[(int'(addr) + i) % 64], "R7 read byte",
            int'(rxQ[i]), int'(expMem[(int'(addr) + i) % 64]));
    end else begin
      for (int i = 0; i < len; i++) begin
        expMem[(int'(addr) + i) % 64] = wdata[8*i +: 8];
        chk(devMem[(int'(addr) + i) % 64] == wdata[8*i +: 8], "R3 written byte",
            int'(devMem[(int'(addr) + i) % 64]), int'(wdata[8*i +: 8]));
      end
    end
  endtask

  task automatic refuse(input int len);
    @(negedge clk);
    reqValid = 1'b1; reqRead = 1'b0; reqAddr = 6'h05; reqLen = TB_LEN_W'(len);
    @(negedge clk);
    reqValid = 1'b0;
    repeat (10) @(negedge clk);
    chk(!busy && !ce && !sclk, "R10 refused length", int'({busy, ce, sclk}), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      devMem[i] = 8'((i * 37 + 5) & 8'hFF);
      expMem[i] = 8'((i * 37 + 5) & 8'hFF);
    end
    repeat (4) @(negedge clk);
    chk(!ce && !sclk && !sdaOe && !busy && !rdValid, "R1 in reset",
        int'({ce, sclk, sdaOe, busy, rdValid}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!ce && !sclk && !sdaOe && !busy && !rdValid, "R1 after reset",
        int'({ce, sclk, sdaOe, busy, rdValid}), 0);

    runTxn(1'b0, 6'h07, 1, 32'h0000_008E, 0, 1'b0);
    runTxn(1'b0, 6'h3E, 4, 32'hA5C3_1E72, 2, 1'b1);
    runTxn(1'b1, 6'h07, 1, '0, 1, 1'b0);
    runTxn(1'b1, 6'h3E, 4, '0, 3, 1'b1);
    runTxn(1'b0, 6'h12, 2, 32'h0000_6901, 1, 1'b0);
    runTxn(1'b1, 6'h11, 3, '0, 0, 1'b0);
    refuse(0);
    refuse(5);

    // R11: host stalls a 3-byte read
    @(posedge clk); #1 rdReady = 1'b0;
    rxQ.delete();
    @(negedge clk);
    divHalf = '0; reqValid = 1'b1; reqRead = 1'b1; reqAddr = 6'h3E; reqLen = 3;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (100) @(negedge clk);
    chk(busy && ce && sclk && rdValid, "R11 clock held high on stall",
        int'({busy, ce, sclk, rdValid}), 4'hF);
    @(posedge clk); #1 rdReady = 1'b1;
    for (int w = 0; w < 500 && busy; w++) @(negedge clk);
    @(negedge clk);
    chk(!busy && rxQ.size() == 3, "R11 all bytes delivered", rxQ.size(), 3);
    for (int i = 0; i < 3 && i < rxQ.size(); i++)
      chk(rxQ[i] == expMem[(62 + i) % 64], "R11 stalled byte",
          int'(rxQ[i]), int'(expMem[(62 + i) % 64]));

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule